// File: doc/BRIEF.md
# Multi-Clock-Type PWM Generator

This block drives a set of pulse-width-modulated outputs, typically fan drives. Each output takes its timing from one of a few shared timebases called clock types. A clock type divides the input clock by a prescale factor. That factor is the product of a power-of-two stage and an even stage. The prescaled tick then steps an 8-bit period counter that wraps at a programmed period value. Ports that select the same type share that counter, so their edges keep a fixed phase relation.

Each port sets its waveform with two points inside the period: a count at which the output rises and a count at which it falls. Fan speed follows the position of the falling point. A port is switched fully off by clearing its enable bit. Setting both points to the same value gives a constant-high output. Software programs everything with single-cycle register writes: a data word, an address and a write strobe. New point values are held in a shadow stage and take effect only at the next wrap of the port's counter, so a change in mid-period cannot cut a pulse short.

Top module: `pwm_multi_type_gen`

## Requirements
- R1: After the synchronous active-high reset, every PWM output is low and all configuration is cleared, which includes the run bit and every port enable.
- R2: A clock type register sits at address 1 + type index. Its bits [7:0] hold the period value P, bits [11:8] the high code H and bits [15:12] the low code L. The prescale divisor is D = 2^H × (1 when L is 0, else 2L). One output period lasts D × (P + 1) clock cycles.
- R3: Duty pair register k sits at address 8 + k. Port 2k uses bits [15:0] and port 2k+1 uses bits [31:16]. In each half, the low byte is the rising point and the high byte is the falling point. The output goes high when its type's counter equals the rising point and low when it equals the falling point. When the rising point is above the falling point, the high interval wraps through the end of the period.
- R4: When the rising point equals the falling point, for example both 0, the output of an enabled port stays constant high.
- R5: The control register is at address 0. Bit 8 + p enables port p. While that bit is clear, the output of port p is low.
- R6: The type select of port p is two bits kept apart in the control register: bit 16 + p is the low bit and bit 24 + p is the high bit. Values 0 to 2 pick a clock type. Value 3 picks none and holds the output low.
- R7: Control bit 0 is the global run bit. While it is clear, every prescaler and period counter holds its value and every enabled output holds its level. When it is set again, counting resumes with the programmed period.
- R8: A rising or falling point written while a port runs takes effect at the next wrap of that port's period counter. While a port is disabled, its points load at once.
- R9: Ports that select the same clock type share one period counter, so the distance between their edges equals the difference of their points times D.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for counting and for register writes |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per register write |
| wr_addr | input | ADDR_W | Register address of the write |
| wr_data | input | DATA_W | Write data |
| pwm_out | output | NUM_PORTS | Registered PWM outputs, one bit per port |

## Verification
The bench builds the block with its default parameters: four ports, three clock types, 8-bit points and periods, and 4-bit divider codes. With four ports, both duty pair registers are used and both halves of each are exercised. With three types, select code 3 is left over as the unused case. The small divider codes in the stimulus table keep every period within a few hundred cycles. Even so, the table still reaches the power-of-two stage, the even stage with L above zero, their product, a wrap-around duty window and the full 256-count period.

// File: rtl/pwm_mt_pkg.sv
package pwm_mt_pkg;

  // Field widths
  localparam int PT_W = 8;   // period counter, rising and falling points
  localparam int DV_W = 4;   // divider codes

  // Register addresses
  localparam int CTRL_ADDR      = 0;
  localparam int TYPE_BASE_ADDR = 1;
  localparam int DUTY_BASE_ADDR = 8;

  // Control register layout
  localparam int RUN_BIT   = 0;
  localparam int EN_LSB    = 8;
  localparam int TSEL0_LSB = 16;
  localparam int TSEL1_LSB = 24;

  // Lane width of a duty pair register
  localparam int HALF_W = 16;

  typedef struct packed {
    logic [DV_W-1:0] ldiv;
    logic [DV_W-1:0] hdiv;
    logic [PT_W-1:0] period;
  } clk_type_t;

  typedef struct packed {
    logic [PT_W-1:0] fall;
    logic [PT_W-1:0] rise;
  } edge_pts_t;

  localparam int TYPE_W = $bits(clk_type_t);
  localparam int PTS_W  = $bits(edge_pts_t);

endpackage

// File: rtl/pwm_mt_regs.sv
module pwm_mt_regs
  import pwm_mt_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int NUM_TYPES = 3,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  output logic                        run,
  output logic [NUM_PORTS-1:0]        port_en,
  output logic [NUM_PORTS-1:0][1:0]   port_tsel,
  output clk_type_t [NUM_TYPES-1:0]   type_cfg,
  output edge_pts_t [NUM_PORTS-1:0]   port_pts
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  logic                      run_q;
  logic [NUM_PORTS-1:0]      en_q;
  logic [NUM_PORTS-1:0][1:0] tsel_q;
  clk_type_t [NUM_TYPES-1:0] type_q;
  edge_pts_t [NUM_PORTS-1:0] pts_q;

  // Reduction only so that data bits beyond the mapped fields count as read
  logic unused_wdata;
  assign unused_wdata = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      en_q   <= '0;
      tsel_q <= '0;
      type_q <= '0;
      pts_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == CTRL_A) begin
        run_q <= wr_data[RUN_BIT];
        for (int p = 0; p < NUM_PORTS; p++) begin
          en_q[p]   <= wr_data[EN_LSB + p];
          tsel_q[p] <= {wr_data[TSEL1_LSB + p], wr_data[TSEL0_LSB + p]};
        end
      end
      for (int t = 0; t < NUM_TYPES; t++) begin
        if (wr_addr == ADDR_W'(TYPE_BASE_ADDR + t))
          type_q[t] <= clk_type_t'(wr_data[TYPE_W-1:0]);
      end
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (wr_addr == ADDR_W'(DUTY_BASE_ADDR + p / 2))
          pts_q[p] <= edge_pts_t'(wr_data[(p % 2) * HALF_W +: PTS_W]);
      end
    end
  end

  assign run       = run_q;
  assign port_en   = en_q;
  assign port_tsel = tsel_q;
  assign type_cfg  = type_q;
  assign port_pts  = pts_q;

  // R6: the two select bits of port 0 come from their separate positions
  p_tsel_capture_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == CTRL_A) |=>
      (port_tsel[0] == {$past(wr_data[TSEL1_LSB]), $past(wr_data[TSEL0_LSB])}));

endmodule

// File: rtl/pwm_mt_timebase.sv
module pwm_mt_timebase
  import pwm_mt_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  clk_type_t       cfg,
  output logic [PT_W-1:0] cnt,
  output logic            wrap
);

  // Widest divisor: 2^(2^DV_W - 1) times 2 * (2^DV_W - 1)
  localparam int PRE_W = (1 << DV_W) - 1 + DV_W + 1;

  logic [PRE_W-1:0] low_div;
  logic [PRE_W-1:0] div_m1;
  logic [PRE_W-1:0] pre_q;
  logic [PT_W-1:0]  cnt_q;
  logic             tick;

  always_comb begin
    if (cfg.ldiv == '0) low_div = PRE_W'(1);
    else                low_div = PRE_W'({cfg.ldiv, 1'b0});
    div_m1 = (low_div << cfg.hdiv) - PRE_W'(1);
  end

  assign tick = run && (pre_q >= div_m1);
  assign wrap = tick && (cnt_q >= cfg.period);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (run) begin
      if (tick) begin
        pre_q <= '0;
        if (cnt_q >= cfg.period) cnt_q <= '0;
        else                     cnt_q <= cnt_q + PT_W'(1);
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end

  assign cnt = cnt_q;

  // R7: a stopped timebase keeps its count
  p_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(cnt));

  // R2: the wrap at the end of a period restarts the count at zero
  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0));

endmodule

// File: rtl/pwm_mt_port.sv
module pwm_mt_port
  import pwm_mt_pkg::*;
#(
  parameter int NUM_TYPES = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            run,
  input  logic                            en,
  input  logic [1:0]                      tsel,
  input  edge_pts_t                       pts,
  input  logic [NUM_TYPES-1:0][PT_W-1:0]  cnt_all,
  input  logic [NUM_TYPES-1:0]            wrap_all,
  output logic                            pwm
);

  logic            sel_ok;
  logic            active;
  logic [PT_W-1:0] cnt_sel;
  logic            wrap_sel;
  edge_pts_t       act_q;
  logic            pwm_q;

  always_comb begin
    sel_ok   = 1'b0;
    cnt_sel  = '0;
    wrap_sel = 1'b0;
    for (int t = 0; t < NUM_TYPES; t++) begin
      if (int'(tsel) == t) begin
        sel_ok   = 1'b1;
        cnt_sel  = cnt_all[t];
        wrap_sel = wrap_all[t];
      end
    end
  end

  assign active = en && sel_ok;

  // Shadow points: load only at a period wrap or while the port is idle
  always_ff @(posedge clk) begin
    if (rst)                       act_q <= '0;
    else if (!active || wrap_sel)  act_q <= pts;
  end

  // A match on the rising point wins over a match on the falling point
  always_ff @(posedge clk) begin
    if (rst)                          pwm_q <= 1'b0;
    else if (!active)                 pwm_q <= 1'b0;
    else if (run) begin
      if (cnt_sel == act_q.rise)      pwm_q <= 1'b1;
      else if (cnt_sel == act_q.fall) pwm_q <= 1'b0;
    end
  end

  assign pwm = pwm_q;

  // R5: an idle port drives low on the next cycle
  p_off_low_r5: assert property (@(posedge clk) disable iff (rst)
    !active |=> !pwm);

  // R4: equal points hold the output high once reached
  p_equal_high_r4: assert property (@(posedge clk) disable iff (rst)
    (active && run && act_q.rise == act_q.fall && cnt_sel == act_q.rise) |=> pwm);

  // R7: a running port keeps its level while counting is stopped
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (active && !run) |=> $stable(pwm));

  // R8: the shadow points of a running port change only at a wrap
  p_shadow_boundary_r8: assert property (@(posedge clk) disable iff (rst)
    (active && !wrap_sel) |=> $stable(act_q));

endmodule

// File: rtl/pwm_multi_type_gen.sv
module pwm_multi_type_gen
  import pwm_mt_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int NUM_TYPES = 3,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [NUM_PORTS-1:0] pwm_out
);

  logic                           run;
  logic [NUM_PORTS-1:0]           port_en;
  logic [NUM_PORTS-1:0][1:0]      port_tsel;
  clk_type_t [NUM_TYPES-1:0]      type_cfg;
  edge_pts_t [NUM_PORTS-1:0]      port_pts;
  logic [NUM_TYPES-1:0][PT_W-1:0] type_cnt;
  logic [NUM_TYPES-1:0]           type_wrap;

  pwm_mt_regs #(
    .NUM_PORTS (NUM_PORTS),
    .NUM_TYPES (NUM_TYPES),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .run       (run),
    .port_en   (port_en),
    .port_tsel (port_tsel),
    .type_cfg  (type_cfg),
    .port_pts  (port_pts)
  );

  for (genvar t = 0; t < NUM_TYPES; t++) begin : g_type
    pwm_mt_timebase u_tb (
      .clk  (clk),
      .rst  (rst),
      .run  (run),
      .cfg  (type_cfg[t]),
      .cnt  (type_cnt[t]),
      .wrap (type_wrap[t])
    );
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    pwm_mt_port #(
      .NUM_TYPES (NUM_TYPES)
    ) u_port (
      .clk      (clk),
      .rst      (rst),
      .run      (run),
      .en       (port_en[p]),
      .tsel     (port_tsel[p]),
      .pts      (port_pts[p]),
      .cnt_all  (type_cnt),
      .wrap_all (type_wrap),
      .pwm      (pwm_out[p])
    );
  end

endmodule

// File: tb/pwm_multi_type_gen_test.sv
module pwm_multi_type_gen_test;

  localparam int NV = 6;
  // Stimulus table: divider codes, period, points, type, port, expected period and high time
  localparam int V_H   [NV] = '{0, 1, 0, 1, 2, 0};
  localparam int V_L   [NV] = '{0, 0, 1, 2, 3, 0};
  localparam int V_P   [NV] = '{9, 4, 7, 3, 2, 255};
  localparam int V_R   [NV] = '{0, 1, 6, 0, 2, 10};
  localparam int V_F   [NV] = '{3, 4, 2, 1, 0, 200};
  localparam int V_T   [NV] = '{0, 1, 2, 0, 1, 2};
  localparam int V_PT  [NV] = '{0, 1, 2, 3, 0, 1};
  localparam int V_PER [NV] = '{10, 10, 16, 32, 72, 256};
  localparam int V_HI  [NV] = '{3, 6, 8, 8, 24, 190};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  pwm_out;

  int checks = 0;
  int failures = 0;
  logic [31:0] ctrl_img = '0;
  logic [31:0] duty_img [2];

  pwm_multi_type_gen uut (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .pwm_out (pwm_out)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_run(input bit b);
    ctrl_img[0] = b;
    wr(4'd0, ctrl_img);
  endtask

  task automatic set_port(input int p, input bit en, input int t);
    ctrl_img[8 + p]  = en;
    ctrl_img[16 + p] = t[0];
    ctrl_img[24 + p] = t[1];
    wr(4'd0, ctrl_img);
  endtask

  task automatic set_type(input int t, input int h, input int l, input int per);
    wr(4'(1 + t), (32'(l) << 12) | (32'(h) << 8) | 32'(per));
  endtask

  task automatic set_duty(input int p, input int r, input int f);
    if (p % 2 == 0) duty_img[p / 2][15:0]  = {8'(f), 8'(r)};
    else            duty_img[p / 2][31:16] = {8'(f), 8'(r)};
    wr(4'(8 + p / 2), duty_img[p / 2]);
  endtask

  // Counts negedges until pwm_out[p] reaches lvl; returns -1 on timeout
  task automatic wait_level(input int p, input logic lvl, output int n);
    n = 0;
    while (pwm_out[p] !== lvl && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (pwm_out[p] !== lvl) n = -1;
  endtask

  task automatic measure(input int p, output int hi, output int per);
    int n, lo;
    wait_level(p, 1'b0, n);
    wait_level(p, 1'b1, n);
    wait_level(p, 1'b0, hi);
    wait_level(p, 1'b1, lo);
    per = (hi < 0 || lo < 0) ? -1 : hi + lo;
  endtask

  task automatic count_high(input int p, input int len, output int n);
    n = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (pwm_out[p] === 1'b1) n++;
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #3000000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    int hi, per, n, lvl, changes;
    duty_img[0] = '0;
    duty_img[1] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 outputs low after reset", int'(pwm_out), 0);

    // Table walk: R2 period, R3 high time, R6 split select, R8 load while idle
    for (int v = 0; v < NV; v++) begin
      ctrl_img = '0;
      set_run(1'b1);
      set_type(V_T[v], V_H[v], V_L[v], V_P[v]);
      set_duty(V_PT[v], V_R[v], V_F[v]);
      set_port(V_PT[v], 1'b1, V_T[v]);
      measure(V_PT[v], hi, per);
      measure(V_PT[v], hi, per);
      chk($sformatf("R2 period vector %0d", v), per, V_PER[v]);
      chk($sformatf("R3 high time vector %0d", v), hi, V_HI[v]);
    end

    // R4: equal points give constant high
    ctrl_img = 32'd1;
    wr(4'd0, ctrl_img);
    set_type(0, 0, 0, 9);
    set_duty(1, 0, 0);
    set_port(1, 1'b1, 0);
    repeat (30) @(negedge clk);
    count_high(1, 40, n);
    chk("R4 equal points constant high", n, 40);

    // R5: disabled port is low
    set_port(1, 1'b0, 0);
    @(negedge clk);
    count_high(1, 40, n);
    chk("R5 disabled port low", n, 0);

    // R6: select code 3 keeps an enabled port low
    set_port(1, 1'b1, 3);
    @(negedge clk);
    count_high(1, 40, n);
    chk("R6 select 3 low", n, 0);
    set_port(1, 1'b0, 0);

    // R7: run bit freezes and resumes
    set_duty(0, 0, 5);
    set_port(0, 1'b1, 0);
    measure(0, hi, per);
    repeat (3) @(negedge clk);
    set_run(1'b0);
    lvl = int'(pwm_out[0]);
    changes = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (int'(pwm_out[0]) != lvl) changes++;
    end
    chk("R7 output frozen while stopped", changes, 0);
    set_run(1'b1);
    measure(0, hi, per);
    chk("R7 period after resume", per, 10);

    // R8: mid-period fall change waits for the wrap
    wait_level(0, 1'b0, n);
    wait_level(0, 1'b1, n);
    duty_img[0][15:0] = {8'd8, 8'd0};
    n = 0;
    while (pwm_out[0] === 1'b1 && n < 100) begin
      if (n == 1) begin
        wr_en = 1'b1; wr_addr = 4'd8; wr_data = duty_img[0];
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    wr_en = 1'b0;
    chk("R8 current period keeps old fall", n, 5);
    wait_level(0, 1'b1, n);
    wait_level(0, 1'b0, hi);
    chk("R8 next period uses new fall", hi, 8);

    // R9: two ports on one type keep a fixed phase
    set_duty(0, 0, 5);
    set_duty(1, 3, 7);
    set_port(1, 1'b1, 0);
    measure(0, hi, per);
    wait_level(0, 1'b0, n);
    wait_level(0, 1'b1, n);
    wait_level(1, 1'b1, n);
    chk("R9 second port rises 3 cycles later", n, 3);
    wait_level(1, 1'b0, hi);
    chk("R9 second port high time", hi, 4);

    summary();
    $finish;
  end

endmodule